// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel stereo sample words into serial audio bit streams. Up to several output lanes share one bit clock and one word clock, which arrive from elsewhere on the chip. All logic runs on the system clock, and it watches both serial clocks as ordinary synchronous inputs. On each falling edge of the bit clock, every lane puts out one bit. A receiver can then capture that bit on the following rising edge.

A runtime format input selects one of three ways to place a word inside each half-frame. The first option delays the MSB by one bit slot, with the word clock low for the left channel. The other two options justify the word against the start or the end of the half-frame, with the word clock high for the left channel. The format is captured at the start of each left half-frame and holds until the next one.

Each lane offers a stereo pair through a valid/ready handshake. The pair is taken only at the moment a left half-frame begins. A lane with nothing on offer at that moment sends zeros for the whole frame. The number of bit slots per half-frame is a parameter, and it must be at least one larger than the word width.

Top module: `sau_serial_tx`

Bit slot k of a half-frame is the k-th detected bit-clock falling edge after a word-clock change. The falling edge that carries the change is slot 0.

## Requirements
- R1: While reset is held and right after it is released, every serial data output is low and every ready output is low.
- R2: With format code 1, or the spare code 3, the word's MSB is in slot 0 and the following bits fill slots 1 to WORD_W-1 in descending order.
- R3: With format code 0, the word's MSB is in slot 1 and its LSB is in slot WORD_W.
- R4: With format code 2, the word's LSB is in the last slot (SLOTS-1) and its MSB is in slot SLOTS-WORD_W.
- R5: Every slot of a half-frame that the word does not occupy is driven low.
- R6: The left word goes out first in each frame and the right word follows in the other half. The left half is the word-clock low level for code 0 and the high level for the other codes.
- R7: All ready outputs are high for exactly one system-clock cycle: the cycle in which a bit-clock fall coincides with the word clock entering the left level. A lane whose valid is high in that cycle takes both its words.
- R8: A lane whose valid is low at the start of a left half-frame sends zeros in both halves of that frame.
- R9: A serial data output changes only in the cycle right after a detected bit-clock fall, that is, a cycle in which the bit clock was high and is now low.
- R10: Each lane sends its own words and follows its own valid input, independently of the other lanes.
- R11: The format code is sampled when a left half-frame starts. A change later in the frame affects only the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Format code: 0 one-slot delay, 1 start-justified, 2 end-justified, 3 as 1 |
| sck_i | input | 1 | Bit clock, sampled on clk |
| ws_i | input | 1 | Word clock, sampled on clk |
| s_valid_i | input | LANES | Per-lane sample offered |
| s_ready_o | output | LANES | Per-lane sample taken in this cycle |
| s_left_i | input | LANES*WORD_W | Left words, lane i at bits [i*WORD_W +: WORD_W] |
| s_right_i | input | LANES*WORD_W | Right words, same packing |
| sd_o | output | LANES | Serial data, one bit per lane |

## Verification
On every cycle, the assertions check four things:
- serial data moves only right after a bit-clock fall;
- the ready pulse lasts one cycle and lands on such a fall;
- the latched format stays put between left-half starts;
- the slots before an end-justified word and after a start-justified or delayed word stay low.

Only the bench's frames can show where each word bit lands, that left comes before right, that the lanes carry separate data, and that an empty offer gives a silent frame. The bench's frames also cover a format change made halfway through a frame.

// File: rtl/sau_tx_pkg.sv
package sau_tx_pkg;

    typedef enum logic [1:0] {
        FMT_DLY1  = 2'd0,
        FMT_START = 2'd1,
        FMT_END   = 2'd2,
        FMT_SPARE = 2'd3
    } fmt_e;

    // word-clock level that marks the left half-frame
    function automatic logic left_level(input fmt_e f);
        return (f != FMT_DLY1);
    endfunction

endpackage

// File: rtl/sau_tx_timing.sv
module sau_tx_timing
    import sau_tx_pkg::*;
#(
    parameter int SLOTS = 20,
    parameter int SW    = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_i,
    input  logic          ws_i,
    input  logic [1:0]    fmt_i,
    output logic          adv_o,
    output logic          lstart_o,
    output logic          is_left_o,
    output logic [SW-1:0] slot_o,
    output fmt_e          fmt_o
);

    localparam logic [SW-1:0] SLOT_MAX = SW'(SLOTS);

    typedef struct packed {
        logic          sck;
        logic          ws;
        logic [SW-1:0] slot;
        fmt_e          fmt;
    } tstate_t;

    tstate_t state_q, state_d;
    logic    fall, ws_edge, lstart;
    fmt_e    fmt_cur;

    always_comb begin
        state_d = state_q;
        fall    = state_q.sck & ~sck_i;
        ws_edge = fall & (ws_i != state_q.ws);
        lstart  = ws_edge & (ws_i == left_level(fmt_e'(fmt_i)));
        fmt_cur = lstart ? fmt_e'(fmt_i) : state_q.fmt;

        state_d.sck = sck_i;
        state_d.fmt = fmt_cur;
        if (fall) begin
            state_d.ws = ws_i;
            if (ws_edge) begin
                state_d.slot = '0;
            end else if (state_q.slot != SLOT_MAX) begin
                state_d.slot = state_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{sck: 1'b0, ws: 1'b0, slot: SLOT_MAX, fmt: FMT_START};
        end else begin
            state_q <= state_d;
        end
    end

    assign adv_o     = fall;
    assign lstart_o  = lstart;
    assign is_left_o = (state_d.ws == left_level(fmt_cur));
    assign slot_o    = state_d.slot;
    assign fmt_o     = fmt_cur;

endmodule

// File: rtl/sau_tx_lane.sv
module sau_tx_lane
    import sau_tx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 20,
    parameter int SW     = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              lstart_i,
    input  logic              is_left_i,
    input  logic [SW-1:0]     slot_i,
    input  fmt_e              fmt_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] left_i,
    input  logic [WORD_W-1:0] right_i,
    output logic              sd_o
);

    localparam int            IW       = $clog2(WORD_W);
    localparam logic [SW-1:0] OFF_DLY  = SW'(1);
    localparam logic [SW-1:0] OFF_END  = SW'(SLOTS - WORD_W);
    localparam logic [SW-1:0] SPAN     = SW'(WORD_W);
    localparam logic [IW-1:0] TOP_BIT  = IW'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] lw;
        logic [WORD_W-1:0] rw;
        logic              sd;
    } lstate_t;

    lstate_t           state_q, state_d;
    logic [WORD_W-1:0] word;
    logic [SW-1:0]     off;
    logic [SW-1:0]     rel;
    logic              bit_now;

    always_comb begin
        state_d = state_q;
        if (lstart_i) begin
            state_d.lw = valid_i ? left_i  : '0;
            state_d.rw = valid_i ? right_i : '0;
        end
        word = is_left_i ? state_d.lw : state_d.rw;

        case (fmt_i)
            FMT_DLY1: off = OFF_DLY;
            FMT_END:  off = OFF_END;
            default:  off = '0;
        endcase

        rel = slot_i - off;
        if ((slot_i >= off) && (rel < SPAN)) begin
            bit_now = word[TOP_BIT - rel[IW-1:0]];
        end else begin
            bit_now = 1'b0;
        end

        if (adv_i) begin
            state_d.sd = bit_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sd_o = state_q.sd;

endmodule

// File: rtl/sau_serial_tx.sv
module sau_serial_tx
    import sau_tx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 20,
    parameter int LANES  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              fmt_i,
    input  logic                    sck_i,
    input  logic                    ws_i,
    input  logic [LANES-1:0]        s_valid_i,
    output logic [LANES-1:0]        s_ready_o,
    input  logic [LANES*WORD_W-1:0] s_left_i,
    input  logic [LANES*WORD_W-1:0] s_right_i,
    output logic [LANES-1:0]        sd_o
);

    localparam int SW = $clog2(SLOTS + 1);

    logic          adv;
    logic          lstart;
    logic          is_left;
    logic [SW-1:0] slot;
    fmt_e          fmt_cur;

    sau_tx_timing #(
        .SLOTS (SLOTS),
        .SW    (SW)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (sck_i),
        .ws_i      (ws_i),
        .fmt_i     (fmt_i),
        .adv_o     (adv),
        .lstart_o  (lstart),
        .is_left_o (is_left),
        .slot_o    (slot),
        .fmt_o     (fmt_cur)
    );

    assign s_ready_o = {LANES{lstart}};

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        sau_tx_lane #(
            .WORD_W (WORD_W),
            .SLOTS  (SLOTS),
            .SW     (SW)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv_i     (adv),
            .lstart_i  (lstart),
            .is_left_i (is_left),
            .slot_i    (slot),
            .fmt_i     (fmt_cur),
            .valid_i   (s_valid_i[gi]),
            .left_i    (s_left_i[gi*WORD_W +: WORD_W]),
            .right_i   (s_right_i[gi*WORD_W +: WORD_W]),
            .sd_o      (sd_o[gi])
        );
    end

endmodule

// File: rtl/sau_serial_tx_chk.sv
module sau_serial_tx_chk #(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 20,
    parameter int LANES  = 3,
    parameter int SW     = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv,
    input logic             lstart,
    input logic [1:0]       fmt_cur,
    input logic [SW-1:0]    slot,
    input logic [LANES-1:0] ready,
    input logic [LANES-1:0] sd
);

    localparam logic [SW-1:0] TAIL_FROM = SW'(WORD_W + 1);
    localparam logic [SW-1:0] LEAD_TO   = SW'(SLOTS - WORD_W);

    assert_sd_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sd));

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready[0] |=> !ready[0]);

    assert_ready_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready[0] |-> adv);

    assert_fmt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lstart |-> $stable(fmt_cur));

    assert_zero_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && fmt_cur != 2'd2 && slot >= TAIL_FROM) |=> (sd == '0));

    assert_zero_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && fmt_cur == 2'd2 && slot < LEAD_TO) |=> (sd == '0));

endmodule

bind sau_serial_tx sau_serial_tx_chk #(
    .WORD_W (WORD_W),
    .SLOTS  (SLOTS),
    .LANES  (LANES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .lstart  (lstart),
    .fmt_cur (fmt_cur),
    .slot    (slot),
    .ready   (s_ready_o),
    .sd      (sd_o)
);

// File: tb/test_sau_serial_tx.sv
module test_sau_serial_tx;

    localparam int W = 16;
    localparam int S = 20;
    localparam int L = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [1:0]     fmt_i;
    logic           sck_i;
    logic           ws_i;
    logic [L-1:0]   s_valid_i;
    logic [L-1:0]   s_ready_o;
    logic [L*W-1:0] s_left_i;
    logic [L*W-1:0] s_right_i;
    logic [L-1:0]   sd_o;

    int   n_checks = 0;
    int   n_err    = 0;
    bit   done     = 0;
    logic cur_ws;
    logic [W-1:0] dl [L];
    logic [W-1:0] dr [L];

    always #5 clk = ~clk;

    sau_serial_tx #(.WORD_W(W), .SLOTS(S), .LANES(L)) i_sau_serial_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_i     (fmt_i),
        .sck_i     (sck_i),
        .ws_i      (ws_i),
        .s_valid_i (s_valid_i),
        .s_ready_o (s_ready_o),
        .s_left_i  (s_left_i),
        .s_right_i (s_right_i),
        .sd_o      (sd_o)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected slot vector of a half-frame: bit k is slot k
    function automatic logic [S-1:0] exp_half(input logic [1:0] f, input logic [W-1:0] w);
        logic [S-1:0] e;
        int off;
        e   = '0;
        off = (f == 2'd0) ? 1 : (f == 2'd2) ? (S - W) : 0;
        for (int k = 0; k < S; k++) begin
            if (k >= off && k < off + W) e[k] = w[W-1-(k-off)];
        end
        return e;
    endfunction

    task automatic slot_step(input logic wsv, output logic [L-1:0] b, output logic [L-1:0] r, inout bit bad);
        @(negedge clk);
        sck_i = 1'b0;
        ws_i  = wsv;
        #1;
        r = s_ready_o;
        @(posedge clk);
        #1;
        if (r != '0) s_valid_i = '0;
        repeat (3) @(negedge clk);
        b = sd_o;
        sck_i = 1'b1;
        repeat (3) @(negedge clk);
        if (sd_o !== b) bad = 1;
    endtask

    task automatic run_frame(input logic [1:0] f, input logic [1:0] fmid, input logic [L-1:0] offer, input string tag);
        logic         lv;
        logic [L-1:0] b, r, rdy0;
        logic [S-1:0] capl [L];
        logic [S-1:0] capr [L];
        bit           bad9, rbad, junk;
        logic [W-1:0] el, er;
        lv    = (f != 2'd0);
        fmt_i = f;
        bad9  = 0;
        rbad  = 0;
        junk  = 0;
        rdy0  = '0;
        if (cur_ws == lv) begin
            for (int k = 0; k < S; k++) slot_step(~lv, b, r, junk);
            cur_ws = ~lv;
        end
        for (int i = 0; i < L; i++) begin
            s_left_i[i*W +: W]  = dl[i];
            s_right_i[i*W +: W] = dr[i];
        end
        s_valid_i = offer;
        for (int k = 0; k < S; k++) begin
            slot_step(lv, b, r, bad9);
            for (int i = 0; i < L; i++) capl[i][k] = b[i];
            if (k == 0) rdy0 = r;
            else if (r != '0) rbad = 1;
        end
        fmt_i = fmid;
        for (int k = 0; k < S; k++) begin
            slot_step(~lv, b, r, bad9);
            for (int i = 0; i < L; i++) capr[i][k] = b[i];
            if (r != '0) rbad = 1;
        end
        cur_ws = ~lv;
        // R7: one ready pulse at the left-half start, none elsewhere (R6)
        check(rdy0 == {L{1'b1}}, {"R7 ready at left start ", tag}, 64'(rdy0), 64'({L{1'b1}}));
        check(!rbad, {"R7 R6 no ready outside left start ", tag}, 64'(rbad), 64'd0);
        check(!bad9, {"R9 data stable between falls ", tag}, 64'(bad9), 64'd0);
        for (int i = 0; i < L; i++) begin
            el = offer[i] ? dl[i] : '0;
            er = offer[i] ? dr[i] : '0;
            // R2/R3/R4/R5 placement, R8 zeros, R10 per lane
            check(capl[i] == exp_half(f, el),
                  $sformatf("R2 R3 R4 R5 R8 R10 left lane%0d fmt%0d %s", i, f, tag),
                  64'(capl[i]), 64'(exp_half(f, el)));
            // R6 right word in the second half, R11 format held
            check(capr[i] == exp_half(f, er),
                  $sformatf("R6 R11 right lane%0d fmt%0d %s", i, f, tag),
                  64'(capr[i]), 64'(exp_half(f, er)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [1:0] f;
        void'($urandom(32'h1A2B_3C4D));
        rst_n     = 1'b0;
        fmt_i     = 2'd1;
        sck_i     = 1'b1;
        ws_i      = 1'b0;
        cur_ws    = 1'b0;
        s_valid_i = '0;
        s_left_i  = '0;
        s_right_i = '0;
        repeat (5) @(negedge clk);
        check(sd_o == '0, "R1 sd in reset", 64'(sd_o), 64'd0);
        check(s_ready_o == '0, "R1 ready in reset", 64'(s_ready_o), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sd_o == '0, "R1 sd after reset", 64'(sd_o), 64'd0);
        check(s_ready_o == '0, "R1 ready after reset", 64'(s_ready_o), 64'd0);

        // directed corners
        for (int i = 0; i < L; i++) begin dl[i] = 16'h8001; dr[i] = 16'h0001 << i; end
        run_frame(2'd1, 2'd1, '1, "start-justified corner");
        for (int i = 0; i < L; i++) begin dl[i] = 16'hC003; dr[i] = 16'h8000 >> i; end
        run_frame(2'd0, 2'd0, '1, "delayed corner");
        for (int i = 0; i < L; i++) begin dl[i] = 16'hA005; dr[i] = 16'hFFFF; end
        run_frame(2'd2, 2'd2, '1, "end-justified corner");
        run_frame(2'd2, 2'd2, '0, "R8 no valid");
        for (int i = 0; i < L; i++) begin dl[i] = 16'h1234 + 16'(i); dr[i] = 16'hFEDC - 16'(i); end
        run_frame(2'd1, 2'd2, 3'b101, "R11 mid-frame change");
        for (int i = 0; i < L; i++) begin dl[i] = 16'h0F0F; dr[i] = 16'hF00F; end
        run_frame(2'd2, 2'd2, 3'b010, "R11 new format next frame");
        run_frame(2'd3, 2'd3, '1, "spare code");

        // random frames
        for (int n = 0; n < 36; n++) begin
            for (int i = 0; i < L; i++) begin
                dl[i] = 16'($urandom);
                dr[i] = 16'($urandom);
            end
            f = 2'($urandom % 4);
            run_frame(f, f, 3'($urandom), "random");
        end
        finish_run();
    end

endmodule